// File: doc/BRIEF.md
# Colour Lookup Table Host Access Port

This block owns three colour lookup RAMs and gives a host a narrow command path into them while the display keeps reading them. Table A is a full-colour table: each of its logical entries is 24 bits wide, but it is held as two 12-bit halves at adjacent half-addresses, with the red byte split across the two halves. Table B holds blue bytes and table C holds green bytes, 256 entries each.

The host drives a 16-bit command word and a select bit per table. Each word sets the table's capture state, and can also load the table's address register or write one data word and then advance that address. The bit order of the word is the protocol: bit 15 releases the table to the display, bit 14 suppresses the write, bit 13 requests an address load, bits 10..0 carry an address and bits 11..0 carry data. A combinational read port presents the entry at a chosen table's current address as two 16-bit words that also carry the three capture flags. Each table has a registered display-side lookup port, which outputs zero while the host holds that table.

Top module: `clut_host_port`

## Requirements
- R1: After reset every table is released (read-word status bits 14..12 are zero), every address register is zero, and all display outputs are zero. Table contents are not cleared by reset.
- R2: A command changes the capture state, the address and the contents only of tables whose `cmd_sel` bit is set. Bit 0 selects A, bit 1 selects B and bit 2 selects C. Tables that are not selected keep all three unchanged.
- R3: Every selected command sets the table's capture state from word bit 15: 0 captures the table for the host, 1 releases it to the display.
- R4: With bit 14 = 1 and bit 13 = 1, the address register is loaded from bits 10..0. B and C keep only bits 7..0. Nothing is written.
- R5: With bit 14 = 0, the data field is written at the current address and the address then increments by one, wrapping to zero past the last entry. A stores bits 11..0; B and C store bits 7..0. Bit 13 is ignored during a write.
- R6: With bit 14 = 1 and bit 13 = 0, the address and the contents stay unchanged.
- R7: Table A's logical entry n occupies half-address 2n, which holds {red[3:0], blue}, and half-address 2n+1, which holds {green, red[7:4]}. The host reads logical entry (A address >> 1), whichever of the two half-addresses is loaded.
- R8: `rd_src` selects the read source: 0 = A, 1 = B, 2 = C, 3 = none. `rd_hi` = {0, capC, capB, capA, green, red[7:4]} and `rd_lo` = {0000, red[3:0], blue}. B supplies blue only and C supplies green only; colour fields a source does not supply read as zero.
- R9: Display outputs are the table contents at the display index, registered one clock after the index. They are zero whenever the table is captured after that edge, so the clock edge that accepts a release already shows the table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_sel | input | 3 | Per-table command select {C, B, A} |
| cmd_word | input | 16 | Command word |
| rd_src | input | 2 | Read source select |
| rd_hi | output | 16 | Read word: status, green, upper red |
| rd_lo | output | 16 | Read word: lower red, blue |
| disp_idx_a | input | A_ENTRY_LOG | Display lookup index into table A |
| disp_idx_b | input | BC_ENTRY_LOG | Display lookup index into table B |
| disp_idx_c | input | BC_ENTRY_LOG | Display lookup index into table C |
| disp_rgb_a | output | 24 | Table A display value {red, green, blue} |
| disp_blue | output | 8 | Table B display value |
| disp_green | output | 8 | Table C display value |

## Verification
The hardest condition to reach from the ports is the state left behind by the less common command combinations: a write word that also carries the load flag, an increment that wraps past the top of a table, and the display output on the exact edge that accepts a release. The bench first fills every table with an arithmetic pattern. It then issues each of these commands against neighbouring entries whose values it already knows, and reads back through the address-load path so that any stray write or wrong address shows up as a pattern mismatch. A mid-run reset after loading non-zero addresses shows that the addresses return to zero while the contents survive.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int WORD_W     = 16;
    localparam int CMD_ADDR_W = 11;
    localparam int CMD_DATA_W = 12;
    localparam int COLOR_W    = 8;

    typedef struct packed {
        logic                  keep_off;   // 1: hand table back to display
        logic                  write_off;  // 1: no write this word
        logic                  load_addr;  // 1: load address (when no write)
        logic [CMD_ADDR_W-1:0] addr_f;
        logic [CMD_DATA_W-1:0] data_f;
    } clut_cmd_t;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } rgb_t;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_C    = 2'd2,
        SRC_NONE = 2'd3
    } rd_src_e;

    function automatic clut_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        clut_cmd_t c;
        c.keep_off  = w[15];
        c.write_off = w[14];
        c.load_addr = w[13];
        c.addr_f    = w[CMD_ADDR_W-1:0];
        c.data_f    = w[CMD_DATA_W-1:0];
        return c;
    endfunction

    // even half {red lo, blue}, odd half {green, red hi}
    function automatic rgb_t join_halves(input logic [CMD_DATA_W-1:0] ev,
                                         input logic [CMD_DATA_W-1:0] od);
        rgb_t c;
        c.red   = {od[3:0], ev[11:8]};
        c.green = od[11:4];
        c.blue  = ev[7:0];
        return c;
    endfunction

    function automatic logic [2*WORD_W-1:0] pack_read(input rgb_t c, input logic [2:0] caps);
        return {1'b0, caps, c.green, c.red[7:4], 4'b0000, c.red[3:0], c.blue};
    endfunction

endpackage

// File: rtl/clut_table.sv
module clut_table
    import clut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int PAIR   = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel,
    input  clut_cmd_t               cmd,
    output logic                    captured,
    output logic [DATA_W-1:0]       host_lo,
    output logic [DATA_W-1:0]       host_hi,
    input  logic [ADDR_W-PAIR-1:0]  disp_idx,
    output logic [DATA_W-1:0]       disp_lo,
    output logic [DATA_W-1:0]       disp_hi
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              cap_d;
    logic              wr_en;
    logic              unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd.addr_f, cmd.data_f};

    always_comb begin
        cap_d  = captured;
        addr_d = addr_q;
        wr_en  = 1'b0;
        if (sel) begin
            cap_d = ~cmd.keep_off;
            if (!cmd.write_off) begin
                wr_en  = 1'b1;
                addr_d = addr_q + 1'b1;
            end else if (cmd.load_addr) begin
                addr_d = cmd.addr_f[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            captured <= 1'b0;
            addr_q   <= '0;
        end else begin
            captured <= cap_d;
            addr_q   <= addr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr_q] <= cmd.data_f[DATA_W-1:0];
    end

    generate
        if (PAIR != 0) begin : g_pair
            assign host_lo = mem[{addr_q[ADDR_W-1:1], 1'b0}];
            assign host_hi = mem[{addr_q[ADDR_W-1:1], 1'b1}];
            always_ff @(posedge clk) begin
                if (rst || cap_d) begin
                    disp_lo <= '0;
                    disp_hi <= '0;
                end else begin
                    disp_lo <= mem[{disp_idx, 1'b0}];
                    disp_hi <= mem[{disp_idx, 1'b1}];
                end
            end
        end else begin : g_single
            assign host_lo = mem[addr_q];
            assign host_hi = '0;
            assign disp_hi = '0;
            always_ff @(posedge clk) begin
                if (rst || cap_d) disp_lo <= '0;
                else              disp_lo <= mem[disp_idx];
            end
        end
    endgenerate

    AST_CAPTURE_FLAG: assert property (@(posedge clk) disable iff (rst)
        sel |=> captured == !$past(cmd.keep_off)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(addr_q) && $stable(captured)); // R2
    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (sel && cmd.write_off && cmd.load_addr) |=> addr_q == $past(cmd.addr_f[ADDR_W-1:0])); // R4
    AST_WRITE_STEP: assert property (@(posedge clk) disable iff (rst)
        (sel && !cmd.write_off) |=> addr_q == $past(addr_q) + 1'b1); // R5
    AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sel && cmd.write_off && !cmd.load_addr) |=> $stable(addr_q)); // R6
    AST_DISP_BLANK: assert property (@(posedge clk) disable iff (rst)
        captured |-> (disp_lo == '0 && disp_hi == '0)); // R9

endmodule

// File: rtl/clut_host_port.sv
module clut_host_port
    import clut_pkg::*;
#(
    parameter int A_ENTRY_LOG  = 10,
    parameter int BC_ENTRY_LOG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2:0]              cmd_sel,
    input  logic [15:0]             cmd_word,
    input  logic [1:0]              rd_src,
    output logic [15:0]             rd_hi,
    output logic [15:0]             rd_lo,
    input  logic [A_ENTRY_LOG-1:0]  disp_idx_a,
    input  logic [BC_ENTRY_LOG-1:0] disp_idx_b,
    input  logic [BC_ENTRY_LOG-1:0] disp_idx_c,
    output logic [23:0]             disp_rgb_a,
    output logic [7:0]              disp_blue,
    output logic [7:0]              disp_green
);
    localparam int A_HALF_W = A_ENTRY_LOG + 1;

    clut_cmd_t cmd;
    logic      cap_a, cap_b, cap_c;
    logic [CMD_DATA_W-1:0] a_lo, a_hi, da_lo, da_hi;
    logic [COLOR_W-1:0]    b_lo, b_hi, c_lo, c_hi, db_hi, dc_hi;
    rgb_t                  src_rgb;
    logic                  unused_sink;

    assign cmd = decode_cmd(cmd_word);
    assign unused_sink = ^{cmd_word[12], b_hi, c_hi, db_hi, dc_hi};

    clut_table #(.ADDR_W(A_HALF_W), .DATA_W(CMD_DATA_W), .PAIR(1)) i_tab_a (
        .clk(clk), .rst(rst), .sel(cmd_sel[0]), .cmd(cmd), .captured(cap_a),
        .host_lo(a_lo), .host_hi(a_hi), .disp_idx(disp_idx_a),
        .disp_lo(da_lo), .disp_hi(da_hi)
    );

    clut_table #(.ADDR_W(BC_ENTRY_LOG), .DATA_W(COLOR_W), .PAIR(0)) i_tab_b (
        .clk(clk), .rst(rst), .sel(cmd_sel[1]), .cmd(cmd), .captured(cap_b),
        .host_lo(b_lo), .host_hi(b_hi), .disp_idx(disp_idx_b),
        .disp_lo(disp_blue), .disp_hi(db_hi)
    );

    clut_table #(.ADDR_W(BC_ENTRY_LOG), .DATA_W(COLOR_W), .PAIR(0)) i_tab_c (
        .clk(clk), .rst(rst), .sel(cmd_sel[2]), .cmd(cmd), .captured(cap_c),
        .host_lo(c_lo), .host_hi(c_hi), .disp_idx(disp_idx_c),
        .disp_lo(disp_green), .disp_hi(dc_hi)
    );

    always_comb begin
        src_rgb = '0;
        case (rd_src_e'(rd_src))
            SRC_A:   src_rgb = join_halves(a_lo, a_hi);
            SRC_B:   src_rgb.blue  = b_lo;
            SRC_C:   src_rgb.green = c_lo;
            default: src_rgb = '0;
        endcase
    end

    assign {rd_hi, rd_lo} = pack_read(src_rgb, {cap_c, cap_b, cap_a});
    assign disp_rgb_a     = join_halves(da_lo, da_hi);

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_sel == 3'b000) |=> $stable(rd_hi[14:12])); // R2
    AST_RESET_RELEASED: assert property (@(posedge clk)
        rst |=> rd_hi[14:12] == 3'b000); // R1

endmodule

// File: tb/test_clut_host_port.sv
module test_clut_host_port;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cmd_sel;
    logic [15:0] cmd_word;
    logic [1:0]  rd_src;
    logic [15:0] rd_hi, rd_lo;
    logic [9:0]  disp_idx_a;
    logic [7:0]  disp_idx_b, disp_idx_c;
    logic [23:0] disp_rgb_a;
    logic [7:0]  disp_blue, disp_green;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clut_host_port i_clut_host_port (
        .clk(clk), .rst(rst), .cmd_sel(cmd_sel), .cmd_word(cmd_word),
        .rd_src(rd_src), .rd_hi(rd_hi), .rd_lo(rd_lo),
        .disp_idx_a(disp_idx_a), .disp_idx_b(disp_idx_b), .disp_idx_c(disp_idx_c),
        .disp_rgb_a(disp_rgb_a), .disp_blue(disp_blue), .disp_green(disp_green)
    );

    function automatic logic [7:0] pr(input int n); return 8'((n * 37 + 5) & 255); endfunction
    function automatic logic [7:0] pg(input int n); return 8'((n * 11 + 3) & 255); endfunction
    function automatic logic [7:0] pb(input int n); return 8'((n * 7 + n / 4 + 1) & 255); endfunction

    function automatic logic [15:0] w_addr(input logic rel, input int a);
        return {rel, 1'b1, 1'b1, 2'b00, 11'(a)};
    endfunction
    function automatic logic [15:0] w_data(input logic rel, input logic [11:0] d);
        return {rel, 1'b0, 1'b0, 1'b0, d};
    endfunction
    function automatic logic [15:0] w_nop(input logic rel);
        return {rel, 1'b1, 1'b0, 13'd0};
    endfunction

    function automatic logic [31:0] exp_rgb(input logic [7:0] r, input logic [7:0] g,
                                            input logic [7:0] b, input logic [2:0] caps);
        return {1'b0, caps, g, r[7:4], 4'b0000, r[3:0], b};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic issue(input logic [2:0] sel, input logic [15:0] w);
        cmd_sel  = sel;
        cmd_word = w;
        @(negedge clk);
        cmd_sel  = 3'b000;
        cmd_word = 16'h0000;
    endtask

    task automatic read_chk(input string req, input logic [1:0] src, input logic [31:0] exp);
        rd_src = src;
        #1;
        check(req, {rd_hi, rd_lo}, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd_sel = 3'b000; cmd_word = 16'h0000; rd_src = 2'd0;
        disp_idx_a = '0; disp_idx_b = '0; disp_idx_c = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: released, display zero
        rd_src = 2'd0; #1;
        check("R1 status", {29'd0, rd_hi[14:12]}, 32'd0);
        check("R1 disp", {disp_rgb_a, disp_blue}, 32'd0);
        check("R1 disp green", {24'd0, disp_green}, 32'd0);

        // fill A (R7 layout), B and C (R5 low 8 bits)
        issue(3'b001, w_addr(1'b0, 0));
        for (int n = 0; n < 1024; n++) begin
            issue(3'b001, w_data(1'b0, {pr(n)[3:0], pb(n)}));
            issue(3'b001, w_data(1'b0, {pg(n), pr(n)[7:4]}));
        end
        issue(3'b010, w_addr(1'b0, 0));
        for (int n = 0; n < 256; n++) issue(3'b010, w_data(1'b0, {4'hA, pb(n)}));
        issue(3'b100, w_addr(1'b0, 0));
        for (int n = 0; n < 256; n++) issue(3'b100, w_data(1'b0, {4'h5, pg(n)}));

        // R1: reset returns addresses to zero, keeps contents
        issue(3'b111, w_addr(1'b0, 77));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        read_chk("R1 A addr zero", 2'd0, exp_rgb(pr(0), pg(0), pb(0), 3'b000));
        read_chk("R1 B addr zero", 2'd1, exp_rgb(8'd0, 8'd0, pb(0), 3'b000));
        read_chk("R1 C addr zero", 2'd2, exp_rgb(8'd0, pg(0), 8'd0, 3'b000));

        // R7 / R8: readback sweep with all tables captured
        for (int n = 0; n < 1024; n++) begin
            issue(3'b001, w_addr(1'b0, 2 * n));
            read_chk("R7 A even", 2'd0, exp_rgb(pr(n), pg(n), pb(n), 3'b001));
            if (n % 64 == 3) begin
                issue(3'b001, w_addr(1'b0, 2 * n + 1));
                read_chk("R7 A odd", 2'd0, exp_rgb(pr(n), pg(n), pb(n), 3'b001));
            end
        end
        for (int n = 0; n < 256; n++) begin
            issue(3'b110, w_addr(1'b0, n));
            read_chk("R8 B", 2'd1, exp_rgb(8'd0, 8'd0, pb(n), 3'b111));
            read_chk("R8 C", 2'd2, exp_rgb(8'd0, pg(n), 8'd0, 3'b111));
        end
        read_chk("R8 none", 2'd3, exp_rgb(8'd0, 8'd0, 8'd0, 3'b111));

        // R5: load flag ignored during a write
        issue(3'b010, w_addr(1'b0, 5));
        issue(3'b010, {1'b0, 1'b0, 1'b1, 1'b0, 12'h0C3});
        read_chk("R5 write ignores load", 2'd1, exp_rgb(8'd0, 8'd0, pb(6), 3'b111));
        issue(3'b010, w_addr(1'b0, 5));
        read_chk("R5 write data", 2'd1, exp_rgb(8'd0, 8'd0, 8'hC3, 3'b111));
        issue(3'b010, w_data(1'b0, {4'h0, pb(5)}));

        // R5: wrap at top of B
        issue(3'b010, w_addr(1'b0, 255));
        issue(3'b010, w_data(1'b0, 12'hF99));
        read_chk("R5 wrap", 2'd1, exp_rgb(8'd0, 8'd0, pb(0), 3'b111));
        issue(3'b010, w_addr(1'b0, 255));
        read_chk("R5 top entry", 2'd1, exp_rgb(8'd0, 8'd0, 8'h99, 3'b111));
        issue(3'b010, w_data(1'b0, {4'h0, pb(255)}));

        // R5: wrap at top of A
        issue(3'b001, w_addr(1'b0, 2047));
        issue(3'b001, w_data(1'b0, {pg(1023), pr(1023)[7:4]}));
        read_chk("R5 A wrap", 2'd0, exp_rgb(pr(0), pg(0), pb(0), 3'b111));

        // R4: load with B/C truncation (bits 10..8 dropped)
        issue(3'b100, w_addr(1'b0, 11'h700 + 40));
        read_chk("R4 C load truncates", 2'd2, exp_rgb(8'd0, pg(40), 8'd0, 3'b111));

        // R6: no-op keeps address and contents
        issue(3'b010, w_addr(1'b0, 10));
        issue(3'b010, w_nop(1'b0));
        read_chk("R6 nop addr", 2'd1, exp_rgb(8'd0, 8'd0, pb(10), 3'b111));
        issue(3'b010, w_addr(1'b0, 11));
        read_chk("R6 nop contents", 2'd1, exp_rgb(8'd0, 8'd0, pb(11), 3'b111));

        // R2: unselected tables untouched
        issue(3'b100, w_addr(1'b0, 20));
        issue(3'b010, w_data(1'b1, 12'h0EE));
        read_chk("R2 C addr kept", 2'd2, exp_rgb(8'd0, pg(20), 8'd0, 3'b101));
        issue(3'b010, w_addr(1'b0, 11));
        read_chk("R2 B written", 2'd1, exp_rgb(8'd0, 8'd0, 8'hEE, 3'b111));
        issue(3'b010, w_data(1'b0, {4'h0, pb(11)}));
        issue(3'b010, w_addr(1'b0, 20));
        read_chk("R2 B not loaded", 2'd1, exp_rgb(8'd0, 8'd0, pb(20), 3'b111));

        // R3: release / capture per table
        issue(3'b010, w_nop(1'b1));
        read_chk("R3 B release", 2'd3, exp_rgb(8'd0, 8'd0, 8'd0, 3'b101));
        issue(3'b101, w_nop(1'b1));
        read_chk("R3 all released", 2'd3, exp_rgb(8'd0, 8'd0, 8'd0, 3'b000));

        // R9: display sweep, one-cycle registered lookup
        for (int n = 0; n < 1024; n++) begin
            disp_idx_a = 10'(n);
            disp_idx_b = 8'(n);
            disp_idx_c = 8'(n + 1);
            @(negedge clk);
            check("R9 disp A", {8'd0, disp_rgb_a}, {8'd0, pr(n), pg(n), pb(n)});
            check("R9 disp BC", {16'd0, disp_blue, disp_green},
                  {16'd0, pb(n & 255), pg((n + 1) & 255)});
        end

        // R9: blank while captured, content on release edge
        disp_idx_a = 10'd3; disp_idx_b = 8'd9; disp_idx_c = 8'd12;
        issue(3'b001, w_nop(1'b0));
        check("R9 A blank", {8'd0, disp_rgb_a}, 32'd0);
        check("R2 B disp live", {24'd0, disp_blue}, {24'd0, pb(9)});
        issue(3'b001, w_nop(1'b1));
        check("R9 A release edge", {8'd0, disp_rgb_a}, {8'd0, pr(3), pg(3), pb(3)});
        issue(3'b010, w_addr(1'b0, 0));
        check("R9 B blank", {24'd0, disp_blue}, 32'd0);
        check("R2 C disp live", {24'd0, disp_green}, {24'd0, pg(12)});
        issue(3'b010, w_nop(1'b1));
        check("R9 B release edge", {24'd0, disp_blue}, {24'd0, pb(9)});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule